// File: doc/BRIEF.md
# Ingress Frame Rate Limiter

This block polices the rate at which frames enter a switch. It keeps one token bucket for every pair of port and priority. When a frame starts, the block checks the bucket for that pair and returns an accept or drop decision one cycle later. When an accepted frame ends, the block debits its length from the same bucket. Every bucket is refilled at a fixed tick by an amount set by its programmed rate code. One code unit is 64 kbit/s, so the highest code, 1375, gives 88 Mbit/s.

Each port chooses which frame class it polices: all frames, multicast only, broadcast only, or flooded unicast only. Frames of other classes pass through and cost nothing. Each port can also charge extra bytes per frame, beyond the span from destination address to FCS, for the preamble, for the minimum inter-frame gap, or for both. A port running at 10 Mbit/s treats any rate code above the 10 Mbit/s point as no limit.

Top module: `rl_ingress_limiter`

## Requirements
- R1: For each cycle with `fs_valid` high, `dec_valid` is high in the next cycle, and `dec_port` and `dec_prio` repeat the port and priority of that start. `dec_valid` is low in every other cycle.
- R2: A frame of a policed class is accepted when the level of its bucket is greater than zero at frame start. It is dropped (`dec_drop`=1) when the level is zero or below.
- R3: When an accepted, policed frame ends (`fe_valid` with its port), its counted length is subtracted from its bucket. A dropped frame's end subtracts nothing.
- R4: The counted length is `fe_len` plus the port's overhead. The 2-bit overhead field per port, at bits [2p+1:2p] of `cfg_ovh`, takes these codes: 0 adds nothing, 1 adds 8 preamble bytes, 2 adds 12 gap bytes, 3 adds 20.
- R5: The 2-bit select field per port, at bits [2p+1:2p] of `cfg_sel`, picks the policed class: 0 all, 1 multicast, 2 broadcast, 3 flooded unicast. `fs_class` codes are 0 known unicast, 1 flooded unicast, 2 multicast, 3 broadcast. Frames of a class that is not selected are always accepted and never debited.
- R6: After reset every bucket holds `BUCKET_MAX` bytes. Once every `TICK_CYCLES` cycles, each bucket gains rate code × `BYTES_PER_CODE` bytes, and its level never goes above `BUCKET_MAX`.
- R7: A bucket is unlimited, and always accepts, when its rate code is 0, or when its port has `cfg_link10` set and the code is above `LINK10_MAX_CODE` (156).
- R8: Buckets are independent. The rate code of port p, priority q sits at `cfg_rate[(p*NUM_PRIO+q)*RATE_W +: RATE_W]`, and draining one bucket does not change decisions for any other bucket.
- R9: While reset is asserted and in the first cycle after it, `dec_valid` and `dec_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_valid | input | 1 | Frame start event |
| fs_port | input | PORT_W | Ingress port of the starting frame |
| fs_prio | input | PRIO_W | Priority of the starting frame |
| fs_class | input | 2 | Class of the starting frame |
| fe_valid | input | 1 | Frame end event |
| fe_port | input | PORT_W | Ingress port of the ending frame |
| fe_len | input | LEN_W | Destination address to FCS length in bytes |
| cfg_rate | input | NUM_PORTS*NUM_PRIO*RATE_W | Rate codes, one per bucket |
| cfg_sel | input | 2*NUM_PORTS | Policed class select per port |
| cfg_ovh | input | 2*NUM_PORTS | Overhead select per port |
| cfg_link10 | input | NUM_PORTS | Port runs at 10 Mbit/s |
| dec_valid | output | 1 | Decision valid |
| dec_drop | output | 1 | 1 means drop, 0 means accept |
| dec_port | output | PORT_W | Port of the decision |
| dec_prio | output | PRIO_W | Priority of the decision |

## Verification
On every cycle the assertions check these properties. A decision follows each start by exactly one cycle. An unselected or unlimited frame is never dropped. A policed frame is dropped exactly when its bucket is empty. No level goes above its cap. A level rises only on a tick, or when its bucket becomes unlimited. The exact byte accounting can only be seen in the bench's scenarios. Those scenarios cover the four overhead amounts measured to the byte, the class filtering for each select mode, the way a dropped frame leaves its bucket alone, refill after a tick, and the 10 Mbit/s threshold at codes 156 and 157.

// File: rtl/rl_pkg.sv
package rl_pkg;

  typedef enum logic [1:0] {
    CLS_KNOWN_UC = 2'd0,
    CLS_FLOOD_UC = 2'd1,
    CLS_MCAST    = 2'd2,
    CLS_BCAST    = 2'd3
  } frame_class_e;

  typedef enum logic [1:0] {
    SEL_ALL   = 2'd0,
    SEL_MCAST = 2'd1,
    SEL_BCAST = 2'd2,
    SEL_FLOOD = 2'd3
  } sel_mode_e;

  typedef enum logic [1:0] {
    OVH_NONE     = 2'd0,
    OVH_PREAMBLE = 2'd1,
    OVH_IFG      = 2'd2,
    OVH_BOTH     = 2'd3
  } ovh_mode_e;

  localparam int unsigned PREAMBLE_BYTES = 8;
  localparam int unsigned IFG_BYTES      = 12;

  // Bytes charged for one frame: DA..FCS length plus selected overhead.
  function automatic logic [31:0] fn_counted_len(logic [31:0] len, ovh_mode_e ovh);
    logic [31:0] extra;
    case (ovh)
      OVH_PREAMBLE: extra = PREAMBLE_BYTES;
      OVH_IFG:      extra = IFG_BYTES;
      OVH_BOTH:     extra = PREAMBLE_BYTES + IFG_BYTES;
      default:      extra = 32'd0;
    endcase
    return len + extra;
  endfunction

  // Whether a frame class is policed under a select mode.
  function automatic logic fn_class_hit(sel_mode_e mode, frame_class_e cls);
    case (mode)
      SEL_MCAST: return cls == CLS_MCAST;
      SEL_BCAST: return cls == CLS_BCAST;
      SEL_FLOOD: return cls == CLS_FLOOD_UC;
      default:   return 1'b1;
    endcase
  endfunction

  // Code zero disables policing; a slow link ignores codes above its speed.
  function automatic logic fn_unlimited(logic [31:0] code, logic link10,
                                        logic [31:0] slow_max);
    return (code == 32'd0) || (link10 && (code > slow_max));
  endfunction

  // Bytes added per tick, clipped to the bucket size.
  function automatic logic [31:0] fn_refill(logic [31:0] code, logic [31:0] per_code,
                                            logic [31:0] cap);
    logic [31:0] amt;
    amt = code * per_code;
    return (amt > cap) ? cap : amt;
  endfunction

endpackage

// File: rtl/rl_tick_gen.sv
module rl_tick_gen #(
  parameter int TICK_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rl_frame_track.sv
module rl_frame_track #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2,
  parameter int PRIO_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [PORT_W-1:0] start_port,
  input  logic [PRIO_W-1:0] start_prio,
  input  logic              start_charge,
  input  logic              end_valid,
  input  logic [PORT_W-1:0] end_port,
  output logic              debit_valid,
  output logic [PRIO_W-1:0] debit_prio
);
  logic              act_q  [NUM_PORTS];
  logic              chg_q  [NUM_PORTS];
  logic [PRIO_W-1:0] prio_q [NUM_PORTS];

  assign debit_valid = end_valid && act_q[end_port] && chg_q[end_port];
  assign debit_prio  = prio_q[end_port];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        act_q[p]  <= 1'b0;
        chg_q[p]  <= 1'b0;
        prio_q[p] <= '0;
      end
    end else begin
      if (end_valid) act_q[end_port] <= 1'b0;
      // A start on the same port in the same cycle opens the next frame.
      if (start_valid) begin
        act_q[start_port]  <= 1'b1;
        chg_q[start_port]  <= start_charge;
        prio_q[start_port] <= start_prio;
      end
    end
  end
endmodule

// File: rtl/rl_bucket.sv
module rl_bucket #(
  parameter int LVL_W      = 16,
  parameter int BUCKET_MAX = 16384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [LVL_W-1:0]        refill,
  input  logic                    unlimited,
  input  logic                    debit,
  input  logic [LVL_W-1:0]        debit_len,
  output logic signed [LVL_W-1:0] level,
  output logic                    ok
);
  localparam int SUM_W = LVL_W + 2;
  localparam logic signed [SUM_W-1:0] CAP_S = SUM_W'(BUCKET_MAX);

  logic signed [SUM_W-1:0] add_s, sub_s, sum_s;
  logic signed [LVL_W-1:0] next_lvl;

  always_comb begin
    add_s = tick  ? signed'(SUM_W'(refill))    : '0;
    sub_s = debit ? signed'(SUM_W'(debit_len)) : '0;
    sum_s = SUM_W'(level) + add_s - sub_s;
    if (unlimited || (sum_s > CAP_S)) next_lvl = LVL_W'(BUCKET_MAX);
    else                              next_lvl = sum_s[LVL_W-1:0];
  end

  assign ok = unlimited || (level > 0);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= LVL_W'(BUCKET_MAX);
    else        level <= next_lvl;
  end
endmodule

// File: rtl/rl_ingress_limiter.sv
module rl_ingress_limiter
  import rl_pkg::*;
#(
  parameter int NUM_PORTS       = 3,
  parameter int NUM_PRIO        = 4,
  parameter int RATE_W          = 11,
  parameter int LEN_W           = 11,
  parameter int TICK_CYCLES     = 125000,
  parameter int BYTES_PER_CODE  = 8,
  parameter int BUCKET_MAX      = 16384,
  parameter int LINK10_MAX_CODE = 156,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fs_valid,
  input  logic [PORT_W-1:0]               fs_port,
  input  logic [PRIO_W-1:0]               fs_prio,
  input  logic [1:0]                      fs_class,
  input  logic                            fe_valid,
  input  logic [PORT_W-1:0]               fe_port,
  input  logic [LEN_W-1:0]                fe_len,
  input  logic [NUM_PORTS*NUM_PRIO*RATE_W-1:0] cfg_rate,
  input  logic [2*NUM_PORTS-1:0]          cfg_sel,
  input  logic [2*NUM_PORTS-1:0]          cfg_ovh,
  input  logic [NUM_PORTS-1:0]            cfg_link10,
  output logic                            dec_valid,
  output logic                            dec_drop,
  output logic [PORT_W-1:0]               dec_port,
  output logic [PRIO_W-1:0]               dec_prio
);
  localparam int NB    = NUM_PORTS * NUM_PRIO;
  localparam int BKT_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int LVL_W = $clog2(BUCKET_MAX + 4096) + 2;

  // Named internal events (observed by the bound checker).
  logic                  tick;
  logic [NB*LVL_W-1:0]   lvl_flat;
  logic [NB-1:0]         bkt_unlim;
  logic [NB-1:0]         bkt_ok;
  logic [BKT_W-1:0]      start_idx;
  logic                  start_sel_hit;
  logic                  start_unlim;
  logic                  start_ok;
  logic                  start_drop;
  logic                  deb_valid;
  logic [PRIO_W-1:0]     deb_prio;
  logic [BKT_W-1:0]      deb_idx;
  logic [LVL_W-1:0]      deb_len;
  logic [31:0]           deb_len_w;

  rl_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // Start-of-frame decision.
  always_comb begin
    start_idx     = BKT_W'(int'(fs_port) * NUM_PRIO + int'(fs_prio));
    start_sel_hit = fn_class_hit(sel_mode_e'(cfg_sel[2*fs_port +: 2]),
                                 frame_class_e'(fs_class));
    start_unlim   = bkt_unlim[start_idx];
    start_ok      = bkt_ok[start_idx];
    start_drop    = start_sel_hit && !start_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_drop  <= 1'b0;
      dec_port  <= '0;
      dec_prio  <= '0;
    end else begin
      dec_valid <= fs_valid;
      dec_drop  <= fs_valid && start_drop;
      if (fs_valid) begin
        dec_port <= fs_port;
        dec_prio <= fs_prio;
      end
    end
  end

  rl_frame_track #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PRIO_W(PRIO_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .start_valid(fs_valid), .start_port(fs_port), .start_prio(fs_prio),
    .start_charge(start_sel_hit && start_ok),
    .end_valid(fe_valid), .end_port(fe_port),
    .debit_valid(deb_valid), .debit_prio(deb_prio)
  );

  // End-of-frame debit.
  always_comb begin
    deb_idx   = BKT_W'(int'(fe_port) * NUM_PRIO + int'(deb_prio));
    deb_len_w = fn_counted_len(32'(fe_len), ovh_mode_e'(cfg_ovh[2*fe_port +: 2]));
    deb_len   = deb_len_w[LVL_W-1:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    localparam int PORT_IDX = b / NUM_PRIO;
    logic [31:0]             refill_w;
    logic signed [LVL_W-1:0] lvl;

    always_comb begin
      refill_w     = fn_refill(32'(cfg_rate[b*RATE_W +: RATE_W]),
                               32'(BYTES_PER_CODE), 32'(BUCKET_MAX));
      bkt_unlim[b] = fn_unlimited(32'(cfg_rate[b*RATE_W +: RATE_W]),
                                  cfg_link10[PORT_IDX], 32'(LINK10_MAX_CODE));
    end

    rl_bucket #(.LVL_W(LVL_W), .BUCKET_MAX(BUCKET_MAX)) u_bucket (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .refill(refill_w[LVL_W-1:0]), .unlimited(bkt_unlim[b]),
      .debit(deb_valid && (deb_idx == BKT_W'(b))), .debit_len(deb_len),
      .level(lvl), .ok(bkt_ok[b])
    );

    assign lvl_flat[b*LVL_W +: LVL_W] = lvl;
  end
endmodule

// File: rtl/rl_ingress_limiter_chk.sv
module rl_ingress_limiter_chk #(
  parameter int NB         = 12,
  parameter int LVL_W      = 17,
  parameter int BUCKET_MAX = 16384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_valid,
  input logic              dec_valid,
  input logic              dec_drop,
  input logic              tick,
  input logic              start_sel_hit,
  input logic              start_unlim,
  input logic              start_ok,
  input logic [NB-1:0]     bkt_unlim,
  input logic [NB*LVL_W-1:0] lvl_flat
);
  localparam logic signed [LVL_W-1:0] CAP_S = LVL_W'(BUCKET_MAX);

  a_r1_dec_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |=> dec_valid);
  a_r1_no_spurious_dec: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_valid |=> !dec_valid);
  a_r5_unselected_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid && !start_sel_hit) |=> !dec_drop);
  a_r7_unlimited_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid && start_unlim) |=> !dec_drop);
  a_r2_credit_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid && start_ok) |=> !dec_drop);
  a_r2_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_valid && start_sel_hit && !start_ok) |=> dec_drop);
  a_r1_drop_only_with_dec: assert property (@(posedge clk) disable iff (!rst_n)
    dec_drop |-> dec_valid);

  for (genvar i = 0; i < NB; i++) begin : g_lvl
    a_r6_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(lvl_flat[i*LVL_W +: LVL_W]) <= CAP_S);
    a_r6_rise_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bkt_unlim[i]) |=>
        ($signed(lvl_flat[i*LVL_W +: LVL_W]) <= $signed($past(lvl_flat[i*LVL_W +: LVL_W]))));
  end
endmodule

bind rl_ingress_limiter rl_ingress_limiter_chk #(
  .NB(NB), .LVL_W(LVL_W), .BUCKET_MAX(BUCKET_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .dec_valid(dec_valid),
  .dec_drop(dec_drop), .tick(tick), .start_sel_hit(start_sel_hit),
  .start_unlim(start_unlim), .start_ok(start_ok), .bkt_unlim(bkt_unlim),
  .lvl_flat(lvl_flat)
);

// File: tb/rl_ingress_limiter_bench.sv
module rl_ingress_limiter_bench;
  localparam int NP   = 3;
  localparam int NQ   = 4;
  localparam int RW   = 11;
  localparam int LW   = 11;
  localparam int TICK = 200;
  localparam int CAP  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_valid = 1'b0;
  logic [1:0] fs_port = '0;
  logic [1:0] fs_prio = '0;
  logic [1:0] fs_class = '0;
  logic fe_valid = 1'b0;
  logic [1:0] fe_port = '0;
  logic [LW-1:0] fe_len = '0;
  logic [NP*NQ*RW-1:0] cfg_rate;
  logic [2*NP-1:0] cfg_sel = '0;
  logic [2*NP-1:0] cfg_ovh = '0;
  logic [NP-1:0] cfg_link10 = '0;
  logic dec_valid, dec_drop;
  logic [1:0] dec_port, dec_prio;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  rl_ingress_limiter #(
    .NUM_PORTS(NP), .NUM_PRIO(NQ), .RATE_W(RW), .LEN_W(LW),
    .TICK_CYCLES(TICK), .BYTES_PER_CODE(8), .BUCKET_MAX(CAP), .LINK10_MAX_CODE(156)
  ) u_rl_ingress_limiter (
    .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .fs_port(fs_port),
    .fs_prio(fs_prio), .fs_class(fs_class), .fe_valid(fe_valid), .fe_port(fe_port),
    .fe_len(fe_len), .cfg_rate(cfg_rate), .cfg_sel(cfg_sel), .cfg_ovh(cfg_ovh),
    .cfg_link10(cfg_link10), .dec_valid(dec_valid), .dec_drop(dec_drop),
    .dec_port(dec_port), .dec_prio(dec_prio)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_rate(input int p, input int q, input int code);
    cfg_rate[(p*NQ+q)*RW +: RW] = RW'(code);
  endtask

  // Wait so that the next n edges contain no refill tick.
  task automatic wait_quiet(input int n);
    @(negedge clk);
    while (((cyc % TICK) < 3) || ((cyc % TICK) > TICK - n - 3)) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame(input int p, input int q, input int cls,
                             input int exp_drop, input string req);
    @(negedge clk);
    fs_valid = 1'b1; fs_port = 2'(p); fs_prio = 2'(q); fs_class = 2'(cls);
    @(negedge clk);
    fs_valid = 1'b0;
    check(req, int'(dec_valid), 1);
    check(req, int'(dec_drop), exp_drop);
    check(req, int'(dec_port), p);
    check(req, int'(dec_prio), q);
  endtask

  task automatic end_frame(input int p, input int len);
    @(negedge clk);
    fe_valid = 1'b1; fe_port = 2'(p); fe_len = LW'(len);
    @(negedge clk);
    fe_valid = 1'b0;
  endtask

  task automatic frame(input int p, input int q, input int cls, input int len,
                       input int exp_drop, input string req);
    start_frame(p, q, cls, exp_drop, req);
    end_frame(p, len);
  endtask

  // Bring a bucket back to full and leave it at rate code 1.
  task automatic refill_full(input int p, input int q);
    set_rate(p, q, 1375);
    wait_cycles(2*TICK + 5);
    set_rate(p, q, 1);
  endtask

  task automatic t_reset;
    check("R9 dec_valid after reset", int'(dec_valid), 0);
    check("R9 dec_drop after reset", int'(dec_drop), 0);
  endtask

  task automatic t_basic;
    wait_quiet(30);
    frame(0, 0, 0, 1000, 0, "R2 first frame accepted");
    @(negedge clk);
    check("R1 dec_valid low without start", int'(dec_valid), 0);
    frame(0, 0, 0, 1000, 0, "R2 second frame accepted");
    start_frame(0, 0, 0, 1, "R2 empty bucket drops");
    end_frame(0, 1500);
    frame(0, 1, 0, 64, 0, "R8 other priority unaffected");
    frame(1, 0, 0, 64, 0, "R8 other port unaffected");
    wait_cycles(TICK + 5);
    frame(0, 0, 0, 64, 0, "R3 dropped frame not debited, R6 refill");
  endtask

  // Two frames then a probe; exp_drop tells the byte-exact overhead result.
  task automatic t_ovh_pair(input int p, input int q, input int ovh,
                            input int l1, input int l2, input int exp_drop,
                            input string req);
    cfg_ovh[2*p +: 2] = 2'(ovh);
    refill_full(p, q);
    wait_quiet(30);
    frame(p, q, 0, l1, 0, req);
    frame(p, q, 0, l2, 0, req);
    frame(p, q, 0, 64, exp_drop, req);
    cfg_ovh[2*p +: 2] = 2'd0;
  endtask

  task automatic t_overhead;
    t_ovh_pair(1, 1, 1, 992, 992, 1, "R4 preamble +8 empties");
    t_ovh_pair(2, 1, 1, 992, 991, 0, "R4 preamble +8 leaves 1");
    t_ovh_pair(1, 2, 2, 988, 988, 1, "R4 gap +12 empties");
    t_ovh_pair(2, 2, 2, 988, 987, 0, "R4 gap +12 leaves 1");
    t_ovh_pair(1, 3, 3, 980, 980, 1, "R4 both +20 empties");
    t_ovh_pair(2, 3, 3, 980, 979, 0, "R4 both +20 leaves 1");
    t_ovh_pair(1, 0, 0, 1000, 999, 0, "R4 none leaves 1");
  endtask

  task automatic t_sel(input int mode, input int hit_cls, input int miss_cls,
                       input string req);
    cfg_sel[1:0] = 2'(mode);
    refill_full(0, 2);
    wait_quiet(40);
    frame(0, 2, miss_cls, 2000, 0, req);
    frame(0, 2, miss_cls, 2000, 0, req);
    frame(0, 2, hit_cls, 1000, 0, req);
    frame(0, 2, hit_cls, 1000, 0, req);
    frame(0, 2, hit_cls, 64, 1, req);
    frame(0, 2, miss_cls, 64, 0, req);
    cfg_sel[1:0] = 2'd0;
  endtask

  task automatic t_select;
    t_sel(1, 2, 3, "R5 multicast mode");
    t_sel(2, 3, 2, "R5 broadcast mode");
    t_sel(3, 1, 0, "R5 flooded unicast mode");
  endtask

  task automatic t_cap;
    set_rate(0, 3, 1375);
    wait_cycles(3*TICK);
    set_rate(0, 3, 1);
    wait_quiet(20);
    frame(0, 3, 0, 2000, 0, "R6 full bucket accepts");
    frame(0, 3, 0, 64, 1, "R6 level capped at max");
  endtask

  task automatic t_unlim;
    cfg_link10[2] = 1'b1;
    set_rate(2, 0, 157);
    wait_quiet(30);
    frame(2, 0, 0, 2047, 0, "R7 code 157 slow link");
    frame(2, 0, 0, 2047, 0, "R7 code 157 slow link");
    frame(2, 0, 0, 2047, 0, "R7 code 157 slow link");
    set_rate(2, 0, 156);
    wait_quiet(30);
    frame(2, 0, 0, 1000, 0, "R7 code 156 limited");
    frame(2, 0, 0, 1000, 0, "R7 code 156 limited");
    frame(2, 0, 0, 64, 1, "R7 code 156 limited");
    cfg_link10[2] = 1'b0;
    set_rate(2, 0, 0);
    wait_quiet(30);
    frame(2, 0, 0, 2047, 0, "R7 code 0 unlimited");
    frame(2, 0, 0, 2047, 0, "R7 code 0 unlimited");
    frame(2, 0, 0, 2047, 0, "R7 code 0 unlimited");
  endtask

  initial begin
    for (int b = 0; b < NP*NQ; b++) cfg_rate[b*RW +: RW] = RW'(1);
    wait_cycles(4);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 dec_valid first cycle", int'(dec_valid), 0);
    t_basic();
    t_overhead();
    t_select();
    t_cap();
    t_unlim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule